// File: doc/BRIEF.md
# Split-Mode Precision Gamma Palette

This block holds two colour correction tables, one for degamma and one for gamma, each with `LUT_SIZE` entries. An entry is a packed 10:10:10 RGB word. A host port programs the tables through two registers. A pointer register sets the starting entry and two control flags. A data register takes one packed entry per write. When the split flag is set, one continuous stream of writes fills the degamma table first and then the gamma table. The pointer moves forward automatically when the auto-increment flag is set.

Three 16-bit ceiling registers, one per colour channel, give the value returned for a pixel input beyond full scale. A mode register chooses between split operation, where the pixel side selects one of the two tables, and plain operation, where only the gamma table is used. The pixel side presents a table position and a channel. One cycle later it receives that channel's entry, scaled to 16 bits, or the channel's ceiling value.

Top module: `gpal_top`

## Requirements
- R1: After a synchronous active-low reset, both tables hold a linear ramp: entry i holds i*1023/(LUT_SIZE-1), rounded down, on every channel. All three ceilings read 0xFFFF. The mode split bit, the pointer, the pointer's split flag and its auto-increment flag are all 0. `pix_out` is 0.
- R2: A data word carries red in bits 29:20, green in bits 19:10 and blue in bits 9:0. On the pixel side, `pix_chan` 0 selects red, 1 selects green, and 2 or 3 selects blue. For an input within range, the lookup returns the 10-bit entry in bits 15:6, with bits 5:0 zero.
- R3: The host registers are at these addresses: 0 pointer, 1 data, 2 red ceiling, 3 green ceiling, 4 blue ceiling, 5 mode (bit 0 = split). In the pointer word, bit 31 is the split flag, bit 15 is auto-increment, and the low log2(2*LUT_SIZE) bits are the position. With auto-increment set, each data write moves the pointer on by one.
- R4: With the split flag set, positions 0 to LUT_SIZE-1 address the degamma table and positions LUT_SIZE to 2*LUT_SIZE-1 address the gamma table. So 2*LUT_SIZE consecutive auto-increment writes from position 0 fill degamma first and then gamma.
- R5: With the split flag clear, data writes go to the gamma table only. The top position bit of a pointer write is ignored, and the auto-increment pointer wraps from LUT_SIZE-1 to 0.
- R6: With the split flag set, the auto-increment pointer wraps from 2*LUT_SIZE-1 to 0.
- R7: With auto-increment clear, a data write overwrites the entry at the current position and leaves the pointer where it is.
- R8: A pixel input greater than LUT_SIZE-1 returns the selected channel's 16-bit ceiling register instead of a table entry.
- R9: With the mode split bit set, `pix_sel` 0 reads degamma and `pix_sel` 1 reads gamma. With it clear, the gamma table is read whatever `pix_sel` is.
- R10: `pix_out` reflects the pixel inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| pix_val | input | log2(LUT_SIZE)+1 | Pixel table position; above LUT_SIZE-1 means beyond full scale |
| pix_chan | input | 2 | Channel select: 0 red, 1 green, 2/3 blue |
| pix_sel | input | 1 | Table select in split mode: 0 degamma, 1 gamma |
| pix_out | output | 16 | Looked-up channel value, registered |

## Verification
The tables are filled with random words in one continuous split stream, and each lookup goes to a random channel in a random table. Data placed in the wrong table, half or field shows up as a mismatch. A direct corner test writes one word past 2*LUT_SIZE, and a second writes in plain mode across position LUT_SIZE-1. Together they tell the two wrap points apart. A repeated write with auto-increment clear must move nothing. Over-range inputs with random ceilings separate the clamp path from the table path. A final random mix of pointer, data, ceiling, mode and lookup operations is checked against a bench model of the register rules.

// File: rtl/gpal_pkg.sv
// Shared definitions for the split-mode precision palette.
// Assumes 10-bit channels and 16-bit ceilings; the table depth is a
// parameter of the modules.
package gpal_pkg;
    localparam int CH_W        = 10;
    localparam int MAX_W       = 16;
    localparam int HOST_W      = 32;
    localparam int SPLIT_BIT   = 31;
    localparam int AUTOINC_BIT = 15;

    typedef enum logic [2:0] {
        REG_PTR   = 3'd0,
        REG_DATA  = 3'd1,
        REG_MAX_R = 3'd2,
        REG_MAX_G = 3'd3,
        REG_MAX_B = 3'd4,
        REG_MODE  = 3'd5
    } reg_addr_e;

    // red occupies the top field so the packed layout matches the data word
    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } entry_t;

    // Linear ramp value for entry i of an n-entry table.
    function automatic logic [CH_W-1:0] ramp_value(input int i, input int n);
        return CH_W'((i * ((1 << CH_W) - 1)) / (n - 1));
    endfunction
endpackage

// File: rtl/gpal_index_ctrl.sv
// Pointer register and data-port sequencer.
// Turns host pointer/data writes into table write strobes, advancing and
// wrapping the pointer. Assumes LUT_SIZE is a power of two.
module gpal_index_ctrl
    import gpal_pkg::*;
#(
    parameter int LUT_SIZE = 32,
    localparam int AW = $clog2(LUT_SIZE),
    localparam int PW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              tbl_we,
    output logic              tbl_sel,
    output logic [AW-1:0]     tbl_addr,
    output entry_t            tbl_data
);
    logic [PW-1:0] ptr_q;
    logic          split_q;
    logic          autoinc_q;
    logic          ptr_wr;
    logic          data_wr;
    logic          at_last;
    logic [PW-1:0] ptr_adv;
    logic          unused_wdata;

    assign unused_wdata = ^{host_wdata[30:16], host_wdata[14:PW]};

    // decode host strobes
    assign ptr_wr  = host_we && (host_addr == REG_PTR);
    assign data_wr = host_we && (host_addr == REG_DATA);

    // wrap point depends on whether the pointer spans both tables
    always_comb begin
        if (split_q) at_last = (ptr_q == PW'(2 * LUT_SIZE - 1));
        else         at_last = (ptr_q[AW-1:0] == AW'(LUT_SIZE - 1));
        ptr_adv = at_last ? '0 : ptr_q + 1'b1;
    end

    // pointer and control flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            split_q   <= 1'b0;
            autoinc_q <= 1'b0;
        end else if (ptr_wr) begin
            split_q   <= host_wdata[SPLIT_BIT];
            autoinc_q <= host_wdata[AUTOINC_BIT];
            ptr_q     <= host_wdata[SPLIT_BIT] ? host_wdata[PW-1:0]
                                               : {1'b0, host_wdata[AW-1:0]};
        end else if (data_wr && autoinc_q) begin
            ptr_q     <= ptr_adv;
        end
    end

    // table write request: top pointer bit picks gamma only in split mode
    assign tbl_we   = data_wr;
    assign tbl_sel  = split_q ? ptr_q[AW] : 1'b1;
    assign tbl_addr = ptr_q[AW-1:0];
    assign tbl_data = entry_t'(host_wdata[3*CH_W-1:0]);

    a_r3_autoinc_step: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && autoinc_q && !at_last |=> ptr_q == $past(ptr_q) + 1'b1);
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && autoinc_q && at_last |=> ptr_q == '0);
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !autoinc_q |=> $stable(ptr_q));
    a_r5_plain_range: assert property (@(posedge clk) disable iff (!rst_n)
        !split_q |-> !ptr_q[AW]);
endmodule

// File: rtl/gpal_cfg_regs.sv
// Per-channel ceiling registers and the mode register.
// Ceilings reset to all ones; the mode split bit resets clear.
module gpal_cfg_regs
    import gpal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [MAX_W-1:0]  max_ch [3],
    output logic              mode_split
);
    logic unused_wdata;
    assign unused_wdata = ^host_wdata[HOST_W-1:MAX_W];

    for (genvar c = 0; c < 3; c++) begin : g_max
        // one ceiling register per channel at consecutive addresses
        always_ff @(posedge clk) begin
            if (!rst_n)
                max_ch[c] <= '1;
            else if (host_we && host_addr == 3'(REG_MAX_R + c))
                max_ch[c] <= host_wdata[MAX_W-1:0];
        end
    end

    // mode register: bit 0 enables split lookups
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_split <= 1'b0;
        else if (host_we && host_addr == REG_MODE)
            mode_split <= host_wdata[0];
    end
endmodule

// File: rtl/gpal_table.sv
// One palette table: LUT_SIZE packed entries, one write port and one
// combinational read port. Reset loads a linear ramp.
module gpal_table
    import gpal_pkg::*;
#(
    parameter int LUT_SIZE = 32,
    localparam int AW = $clog2(LUT_SIZE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wdata,
    input  logic [AW-1:0] raddr,
    output entry_t        rdata
);
    entry_t mem [LUT_SIZE];

    // storage with ramp preset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LUT_SIZE; i++)
                mem[i] <= '{r: ramp_value(i, LUT_SIZE),
                            g: ramp_value(i, LUT_SIZE),
                            b: ramp_value(i, LUT_SIZE)};
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/gpal_lookup.sv
// Pixel-side lookup: picks the table and channel, clamps over-range
// inputs to the channel ceiling, and registers the result (one cycle).
module gpal_lookup
    import gpal_pkg::*;
#(
    parameter int LUT_SIZE = 32,
    localparam int AW = $clog2(LUT_SIZE),
    localparam int PW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    pix_val,
    input  logic [1:0]       pix_chan,
    input  logic             pix_sel,
    input  logic             mode_split,
    input  logic [MAX_W-1:0] max_ch [3],
    input  entry_t           dg_rdata,
    input  entry_t           gm_rdata,
    output logic [AW-1:0]    raddr,
    output logic [MAX_W-1:0] pix_out
);
    logic            over;
    entry_t          ent;
    logic [CH_W-1:0] ch_val;
    logic [1:0]      ch_idx;

    assign raddr  = pix_val[AW-1:0];
    assign over   = pix_val[AW];
    assign ch_idx = (pix_chan == 2'd3) ? 2'd2 : pix_chan;

    // table and channel select
    always_comb begin
        ent = (!mode_split || pix_sel) ? gm_rdata : dg_rdata;
        case (ch_idx)
            2'd0:    ch_val = ent.r;
            2'd1:    ch_val = ent.g;
            default: ch_val = ent.b;
        endcase
    end

    // output register with clamp
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_out <= '0;
        else if (over)
            pix_out <= max_ch[ch_idx];
        else
            pix_out <= {ch_val, {(MAX_W-CH_W){1'b0}}};
    end

    a_r8_clamp_red: assert property (@(posedge clk) disable iff (!rst_n)
        over && pix_chan == 2'd0 |=> pix_out == $past(max_ch[0]));
    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !over |=> pix_out[MAX_W-CH_W-1:0] == '0);
endmodule

// File: rtl/gpal_top.sv
// Split-mode precision gamma palette top: host register port, degamma
// and gamma tables, and a registered pixel lookup. LUT_SIZE must be a
// power of two, at least 2.
module gpal_top
    import gpal_pkg::*;
#(
    parameter int LUT_SIZE = 32,
    localparam int AW = $clog2(LUT_SIZE),
    localparam int PW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic [PW-1:0]     pix_val,
    input  logic [1:0]        pix_chan,
    input  logic              pix_sel,
    output logic [MAX_W-1:0]  pix_out
);
    logic             tbl_we;
    logic             tbl_sel;
    logic [AW-1:0]    tbl_addr;
    entry_t           tbl_data;
    logic [MAX_W-1:0] max_ch [3];
    logic             mode_split;
    logic [AW-1:0]    raddr;
    entry_t           rd [2];

    gpal_index_ctrl #(.LUT_SIZE(LUT_SIZE)) u_ctrl (
        .clk, .rst_n, .host_we, .host_addr, .host_wdata,
        .tbl_we, .tbl_sel, .tbl_addr, .tbl_data
    );

    gpal_cfg_regs u_cfg (
        .clk, .rst_n, .host_we, .host_addr, .host_wdata,
        .max_ch, .mode_split
    );

    // table 0 = degamma, table 1 = gamma
    for (genvar t = 0; t < 2; t++) begin : g_tbl
        gpal_table #(.LUT_SIZE(LUT_SIZE)) u_tbl (
            .clk, .rst_n,
            .we    (tbl_we && (tbl_sel == t[0])),
            .waddr (tbl_addr),
            .wdata (tbl_data),
            .raddr (raddr),
            .rdata (rd[t])
        );
    end

    gpal_lookup #(.LUT_SIZE(LUT_SIZE)) u_lkp (
        .clk, .rst_n, .pix_val, .pix_chan, .pix_sel, .mode_split,
        .max_ch, .dg_rdata(rd[0]), .gm_rdata(rd[1]),
        .raddr, .pix_out
    );
endmodule

// File: tb/test_gpal_top.sv
`timescale 1ns/1ps
module test_gpal_top;
    localparam int N  = 32;
    localparam int AW = $clog2(N);
    localparam int PW = AW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_we = 1'b0;
    logic [2:0]    host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [PW-1:0] pix_val = '0;
    logic [1:0]    pix_chan = '0;
    logic          pix_sel = 1'b0;
    logic [15:0]   pix_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model
    logic [29:0]   m_tbl [2][N];
    logic [15:0]   m_max [3];
    logic          m_mode;
    logic [PW-1:0] m_ptr;
    logic          m_split, m_auto;

    gpal_top #(.LUT_SIZE(N)) i_gpal_top (
        .clk, .rst_n, .host_we, .host_addr, .host_wdata,
        .pix_val, .pix_chan, .pix_sel, .pix_out
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] exp_lookup(logic [PW-1:0] v, logic [1:0] c, logic s);
        int ci = (c == 2'd3) ? 2 : int'(c);
        logic [29:0] e;
        if (v > PW'(N - 1)) return m_max[ci];
        e = m_tbl[(!m_mode || s) ? 1 : 0][v[AW-1:0]];
        case (ci)
            0: return {e[29:20], 6'b0};
            1: return {e[19:10], 6'b0};
            default: return {e[9:0], 6'b0};
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            logic [9:0] r = 10'((i * 1023) / (N - 1));
            m_tbl[0][i] = {r, r, r};
            m_tbl[1][i] = {r, r, r};
        end
        for (int c = 0; c < 3; c++) m_max[c] = 16'hFFFF;
        m_mode = 0; m_ptr = '0; m_split = 0; m_auto = 0;
    endtask

    task automatic host_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        case (a)
            3'd0: begin
                m_split = d[31]; m_auto = d[15];
                m_ptr = d[31] ? d[PW-1:0] : {1'b0, d[AW-1:0]};
            end
            3'd1: begin
                m_tbl[m_split ? int'(m_ptr[AW]) : 1][m_ptr[AW-1:0]] = d[29:0];
                if (m_auto) begin
                    if (m_split ? (m_ptr == PW'(2 * N - 1)) : (m_ptr[AW-1:0] == AW'(N - 1)))
                        m_ptr = '0;
                    else
                        m_ptr = m_ptr + 1'b1;
                end
            end
            3'd2, 3'd3, 3'd4: m_max[a - 3'd2] = d[15:0];
            3'd5: m_mode = d[0];
            default: ;
        endcase
    endtask

    task automatic check_lookup(logic [PW-1:0] v, logic [1:0] c, logic s, string tag);
        logic [15:0] exp;
        @(negedge clk);
        pix_val = v; pix_chan = c; pix_sel = s;
        exp = exp_lookup(v, c, s);
        @(negedge clk);
        checks++;
        if (pix_out !== exp) begin
            fails++;
            $display("FAIL %s: val=%0d chan=%0d sel=%0d actual=%h expected=%h",
                     tag, v, c, s, pix_out, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (pix_out !== 16'h0) begin
            fails++;
            $display("FAIL R1 reset output: actual=%h expected=0000", pix_out);
        end
        for (int i = 0; i < N; i += 7) check_lookup(PW'(i), 2'(i % 3), 1'b1, "R1 ramp");
        check_lookup(PW'(N - 1), 2'd1, 1'b0, "R1 ramp top");
        for (int c = 0; c < 3; c++) check_lookup(PW'(N), 2'(c), 1'b0, "R1 ceiling reset");

        // R4/R3/R2: one split stream fills degamma then gamma
        host_write(3'd0, 32'h8000_8000);
        for (int i = 0; i < 2 * N; i++) host_write(3'd1, $urandom);
        host_write(3'd5, 32'd1);
        for (int i = 0; i < 40; i++)
            check_lookup(PW'($urandom_range(N - 1)), 2'($urandom_range(3)), 1'($urandom_range(1)), "R4 split fill");
        check_lookup(PW'(0), 2'd0, 1'b0, "R2 red field");
        check_lookup(PW'(0), 2'd3, 1'b1, "R2 chan3 blue");

        // R9: mode clear reads gamma regardless of select
        host_write(3'd5, 32'd0);
        for (int i = 0; i < 6; i++) check_lookup(PW'(i * 5), 2'(i % 3), 1'b0, "R9 plain gamma");
        host_write(3'd5, 32'd1);

        // R6: pointer wrapped after 2N writes; next lands in degamma 0
        host_write(3'd1, 32'h1555_5555);
        check_lookup(PW'(0), 2'd0, 1'b0, "R6 split wrap");
        check_lookup(PW'(0), 2'd2, 1'b0, "R6 split wrap");

        // R7: no auto-increment overwrites in place
        host_write(3'd0, 32'h8000_0005);
        host_write(3'd1, 32'h0123_4567);
        host_write(3'd1, 32'h3ABC_DEF0);
        for (int c = 0; c < 3; c++) check_lookup(PW'(5), 2'(c), 1'b0, "R7 overwrite");
        check_lookup(PW'(6), 2'd1, 1'b0, "R7 neighbour untouched");

        // R5: plain pointer, top bit ignored, wrap at N-1 into gamma 0
        host_write(3'd0, 32'h0000_8000 | 32'(2 * N - 1));
        host_write(3'd1, 32'h2AAA_AAAA);
        host_write(3'd1, 32'h0F0F_0F0F);
        check_lookup(PW'(N - 1), 2'd0, 1'b1, "R5 plain last");
        check_lookup(PW'(0), 2'd1, 1'b1, "R5 plain wrap");
        check_lookup(PW'(0), 2'd0, 1'b0, "R5 degamma untouched");
        check_lookup(PW'(N - 1), 2'd2, 1'b0, "R5 degamma untouched");

        // R8: ceilings and clamp
        for (int c = 0; c < 3; c++) host_write(3'(2 + c), $urandom);
        for (int i = 0; i < 12; i++)
            check_lookup(PW'(N + $urandom_range(N - 1)), 2'($urandom_range(3)), 1'($urandom_range(1)), "R8 clamp");

        // R10 and mixed random traffic
        for (int i = 0; i < 300; i++) begin
            int op = $urandom_range(9);
            if (op < 3)      host_write(3'd1, $urandom);
            else if (op == 3) host_write(3'd0, ($urandom & 32'h8000_8000) | 32'($urandom_range(2 * N - 1)));
            else if (op == 4) host_write(3'(2 + $urandom_range(2)), $urandom);
            else if (op == 5) host_write(3'd5, 32'($urandom_range(1)));
            else check_lookup(PW'($urandom_range(2 * N - 1)), 2'($urandom_range(3)), 1'($urandom_range(1)), "R10 random mix");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule